// File: doc/BRIEF.md
# Coalescing Host Interrupt Controller

This block collects hardware event pulses into a 32-bit host status register, gates them with a 32-bit enable mask and drives one interrupt line toward the host. Status bits stay set until the host writes a one to them. A second status register holds per-channel DMA events: receive channels, transmit channels, a high-priority receive flag and a DMA error. It is summarised into three fixed bits of the main status.

To cut the interrupt rate, the line can be held back by a programmable coalescing window counted in 32-microsecond units. The window starts when the first enabled bit becomes pending, so further events pile up behind the same interrupt. A high-priority receive event skips the window. A periodic timer, counted in the same units, raises its own status bit at a fixed rate. A one-cycle-per-microsecond tick input is the only time base.

Top module: `irq_coal_ctrl`

## Requirements
- R1: An event pulse on `evt_i[n]` sets `status_o[n]` at the next clock edge for every n except 31, 29 and 27. Pulses on those three bits of `evt_i` are ignored.
- R2: `status_o` is updated only by host writes with `wr_sel_i` = 0. A one in `wr_data_i` clears the matching bit and a zero leaves it unchanged. A bit that is set and cleared in the same cycle stays set.
- R3: When the coalescing value is 0, `irq_o` equals the OR of `status_o & mask` in the same cycle the status changes.
- R4: When the coalescing value C is nonzero and nothing is pending, a newly pending enabled bit raises `irq_o` after C×32 cycles in which `us_tick_i` is high. With the tick held high, this is C×32+1 clock edges after the edge that set the bit. Cycles in which the tick is low do not advance the window.
- R5: Once raised, `irq_o` stays high while any enabled bit is pending. It drops as soon as none is pending. The next event then opens a new full window.
- R6: The DMA status register (`wr_sel_i` = 2, write-one-to-clear) holds only bits 0, 1 (transmit channels), 16, 17 (receive channels), 30 (high-priority receive) and 31 (DMA error). Events on any other DMA bit are ignored.
- R7: The following main status bits follow the DMA register, and host writes to them have no effect:
  - bit 31 is the OR of DMA bits 16, 17 and 30;
  - bit 27 is the OR of DMA bits 0 and 1;
  - bit 29 is DMA bit 31.
- R8: While DMA bit 30 is set and mask bit 31 is enabled, `irq_o` is high regardless of the coalescing window.
- R9: A configuration write (`wr_sel_i` = 3) sets the coalescing value C from `wr_data_i[7:0]` and the periodic value P from `wr_data_i[15:8]`. For P ≠ 0, main status bit 28 is first set P×32+1 edges after the write, with the tick held high, and then every P×32 ticks. For P = 0 the bit is never set by the timer.
- R10: A write with `wr_sel_i` = 1 loads the enable mask from `wr_data_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| us_tick_i | input | 1 | High for one cycle per microsecond |
| evt_i | input | 32 | Main event pulses, one per status bit |
| dma_evt_i | input | 32 | DMA channel event pulses |
| wr_en_i | input | 1 | Host write strobe |
| wr_sel_i | input | 2 | Write target: 0 status, 1 mask, 2 DMA status, 3 config |
| wr_data_i | input | 32 | Host write data |
| irq_o | output | 1 | Interrupt to host |
| status_o | output | 32 | Main status with DMA summaries |
| dma_status_o | output | 32 | DMA channel status |

## Verification
The hardest case to reach from the ports is the exact edge on which a coalescing window expires. It is hardest when microsecond ticks pause mid-window, or when a window must reopen right after the host drains the pending bits. Directed sequences hold the tick high or low for known spans and count clock edges from the setting event to the rise of `irq_o`. A seeded random phase with coalescing off mixes sparse events, DMA events and write-one-to-clear writes, including set and clear in the same cycle. Every cycle of that phase is compared with a bench model.

// File: rtl/irq_coal_pkg.sv
package irq_coal_pkg;

  typedef enum logic [1:0] {
    SEL_STATUS = 2'd0,
    SEL_MASK   = 2'd1,
    SEL_DMA    = 2'd2,
    SEL_CFG    = 2'd3
  } wr_sel_e;

  localparam int BIT_RX       = 31;
  localparam int BIT_HWERR    = 29;
  localparam int BIT_PERIODIC = 28;
  localparam int BIT_TX       = 27;

  localparam int DMA_ERR   = 31;
  localparam int DMA_HIPRI = 30;
  localparam int DMA_RX1   = 17;
  localparam int DMA_RX0   = 16;
  localparam int DMA_TX1   = 1;
  localparam int DMA_TX0   = 0;

  localparam logic [31:0] SUMMARY_MASK =
    (32'd1 << BIT_RX) | (32'd1 << BIT_HWERR) | (32'd1 << BIT_TX);

  localparam logic [31:0] DMA_VALID_MASK =
    (32'd1 << DMA_ERR) | (32'd1 << DMA_HIPRI) | (32'd1 << DMA_RX1) |
    (32'd1 << DMA_RX0) | (32'd1 << DMA_TX1)   | (32'd1 << DMA_TX0);

endpackage

// File: rtl/irq_w1c_reg.sv
module irq_w1c_reg #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= (q_o & ~clr_i) | set_i;  // set wins
  end

  AST_SET_STICKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|set_i) |=> ((q_o & $past(set_i)) == $past(set_i)));  // R1

  AST_W1C_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(clr_i & ~set_i)) |=> ((q_o & $past(clr_i & ~set_i)) == '0));  // R2

endmodule

// File: rtl/irq_unit_timer.sv
module irq_unit_timer #(
  parameter int UNIT_W      = 8,
  parameter int US_PER_UNIT = 32,
  parameter bit RELOAD      = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [UNIT_W-1:0] units_i,
  input  logic              tick_i,
  output logic              expire_o,
  output logic              busy_o
);

  localparam int CNT_W = UNIT_W + $clog2(US_PER_UNIT);
  localparam logic [CNT_W-1:0] US_CNT = CNT_W'(US_PER_UNIT);
  localparam logic [CNT_W-1:0] ONE    = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] load_val;

  assign load_val = {{(CNT_W-UNIT_W){1'b0}}, units_i} * US_CNT;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      busy_o   <= 1'b0;
      expire_o <= 1'b0;
    end else begin
      expire_o <= 1'b0;
      if (start_i) begin
        cnt_q  <= load_val;
        busy_o <= (units_i != '0);
      end else if (busy_o && tick_i) begin
        if (cnt_q == ONE) begin
          expire_o <= 1'b1;
          if (RELOAD) begin
            cnt_q <= load_val;
          end else begin
            cnt_q  <= '0;
            busy_o <= 1'b0;
          end
        end else begin
          cnt_q <= cnt_q - ONE;
        end
      end
    end
  end

  AST_EXPIRE_AFTER_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o |-> $past(busy_o));  // R4

  AST_BUSY_CNT_LIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (cnt_q != '0));  // R4

endmodule

// File: rtl/irq_coal_ctrl.sv
module irq_coal_ctrl
  import irq_coal_pkg::*;
#(
  parameter int US_PER_UNIT = 32,
  parameter int UNIT_W      = 8
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        us_tick_i,
  input  logic [31:0] evt_i,
  input  logic [31:0] dma_evt_i,
  input  logic        wr_en_i,
  input  logic [1:0]  wr_sel_i,
  input  logic [31:0] wr_data_i,
  output logic        irq_o,
  output logic [31:0] status_o,
  output logic [31:0] dma_status_o
);

  logic              wr_stat, wr_mask, wr_dma, wr_cfg;
  logic [31:0]       mask_q;
  logic [UNIT_W-1:0] coal_q, per_q, per_units;
  logic [31:0]       main_q, main_set, main_clr, dma_set, dma_clr;
  logic              per_exp, per_busy, coal_exp, coal_busy, coal_start;
  logic              fired_q, any_pend, hipri;

  assign wr_stat = wr_en_i && (wr_sel_i == SEL_STATUS);
  assign wr_mask = wr_en_i && (wr_sel_i == SEL_MASK);
  assign wr_dma  = wr_en_i && (wr_sel_i == SEL_DMA);
  assign wr_cfg  = wr_en_i && (wr_sel_i == SEL_CFG);

  // summary positions are driven from the DMA register only
  assign main_set = (evt_i & ~SUMMARY_MASK) | (32'(per_exp) << BIT_PERIODIC);
  assign main_clr = wr_stat ? (wr_data_i & ~SUMMARY_MASK) : '0;
  assign dma_set  = dma_evt_i & DMA_VALID_MASK;
  assign dma_clr  = wr_dma ? wr_data_i : '0;

  irq_w1c_reg #(.W(32)) u_main (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_i(main_set), .clr_i(main_clr), .q_o(main_q)
  );

  irq_w1c_reg #(.W(32)) u_dma (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_i(dma_set), .clr_i(dma_clr), .q_o(dma_status_o)
  );

  always_comb begin
    status_o            = main_q;
    status_o[BIT_RX]    = dma_status_o[DMA_RX0] | dma_status_o[DMA_RX1] |
                          dma_status_o[DMA_HIPRI];
    status_o[BIT_TX]    = dma_status_o[DMA_TX0] | dma_status_o[DMA_TX1];
    status_o[BIT_HWERR] = dma_status_o[DMA_ERR];
  end

  // new period takes effect in the same cycle it is written
  assign per_units = wr_cfg ? wr_data_i[2*UNIT_W-1:UNIT_W] : per_q;

  irq_unit_timer #(.UNIT_W(UNIT_W), .US_PER_UNIT(US_PER_UNIT), .RELOAD(1'b1)) u_per (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(wr_cfg), .units_i(per_units),
    .tick_i(us_tick_i), .expire_o(per_exp), .busy_o(per_busy)
  );

  assign any_pend   = |(status_o & mask_q);
  assign hipri      = dma_status_o[DMA_HIPRI] & mask_q[BIT_RX];
  assign coal_start = any_pend & ~coal_busy & ~fired_q & ~coal_exp & (coal_q != '0);

  irq_unit_timer #(.UNIT_W(UNIT_W), .US_PER_UNIT(US_PER_UNIT), .RELOAD(1'b0)) u_coal (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(coal_start), .units_i(coal_q),
    .tick_i(us_tick_i), .expire_o(coal_exp), .busy_o(coal_busy)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q  <= '0;
      coal_q  <= '0;
      per_q   <= '0;
      fired_q <= 1'b0;
    end else begin
      if (wr_mask) mask_q <= wr_data_i;
      if (wr_cfg) begin
        coal_q <= wr_data_i[UNIT_W-1:0];
        per_q  <= wr_data_i[2*UNIT_W-1:UNIT_W];
      end
      fired_q <= any_pend ? (fired_q | coal_exp) : 1'b0;
    end
  end

  assign irq_o = any_pend & (fired_q | coal_exp | (coal_q == '0) | hipri);

  AST_IRQ_NEEDS_PENDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (|(status_o & mask_q)));  // R5

  AST_HIPRI_BYPASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dma_status_o[DMA_HIPRI] && mask_q[BIT_RX]) |-> irq_o);  // R8

  AST_PERIODIC_OFF_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (per_q == '0) |-> !per_busy);  // R9

endmodule

// File: tb/irq_coal_ctrl_test.sv
module irq_coal_ctrl_test;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        us_tick = 1'b1;
  logic [31:0] evt = '0, dma_evt = '0, wr_data = '0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = '0;
  logic        irq;
  logic [31:0] status, dma_status;

  int n_tests = 0;
  int n_fail  = 0;

  always #4 clk_i = ~clk_i;  // 125 MHz

  irq_coal_ctrl uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .us_tick_i(us_tick), .evt_i(evt),
    .dma_evt_i(dma_evt), .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
    .irq_o(irq), .status_o(status), .dma_status_o(dma_status)
  );

  localparam logic [31:0] SUM = 32'hA800_0000;
  localparam logic [31:0] DVALID = 32'hC003_0003;

  function automatic logic [31:0] f_stat(logic [31:0] m, logic [31:0] d);
    logic [31:0] f;
    f     = m;
    f[31] = d[16] | d[17] | d[30];
    f[27] = d[0] | d[1];
    f[29] = d[31];
    return f;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk_i);
    #1;
  endtask

  task automatic wr(logic [1:0] sel, logic [31:0] data);
    wr_en = 1'b1; wr_sel = sel; wr_data = data;
    cyc();
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic pulse(logic [31:0] e, logic [31:0] d);
    evt = e; dma_evt = d;
    cyc();
    evt = '0; dma_evt = '0;
  endtask

  task automatic count_irq(output int n);
    n = 0;
    while (!irq && n < 400) begin
      cyc();
      n++;
    end
  endtask

  task automatic clear_all();
    wr(2'd0, 32'hFFFF_FFFF);
    wr(2'd2, 32'hFFFF_FFFF);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] m_main, m_dma, m_mask, e, d, clr, dclr;
    logic we;
    logic [1:0] sel;
    int n;
    void'($urandom(32'd20240611));
    repeat (3) cyc();
    rst_ni = 1'b1;
    cyc();
    chk("reset status", status, 32'h0);
    chk("reset dma", dma_status, 32'h0);
    chk("reset irq", {31'd0, irq}, 32'h0);

    // random phase, coalescing 0, periodic off
    m_main = '0; m_dma = '0; m_mask = '0;
    for (int i = 0; i < 300; i++) begin
      e   = $urandom & $urandom & $urandom;
      d   = $urandom & $urandom;
      we  = ($urandom % 3) == 0;
      sel = 2'($urandom % 3);
      evt = e; dma_evt = d;
      wr_en = we; wr_sel = sel; wr_data = $urandom;
      clr  = (we && sel == 2'd0) ? (wr_data & ~SUM) : '0;
      dclr = (we && sel == 2'd2) ? wr_data : '0;
      m_main = (m_main & ~clr) | (e & ~SUM);
      m_dma  = (m_dma & ~dclr) | (d & DVALID);
      if (we && sel == 2'd1) m_mask = wr_data;  // R10
      cyc();
      evt = '0; dma_evt = '0; wr_en = 1'b0;
      chk("R1 R2 R7 status", status, f_stat(m_main, m_dma));
      chk("R6 dma status", dma_status, m_dma);
      chk("R3 R10 immediate irq", {31'd0, irq}, {31'd0, |(f_stat(m_main, m_dma) & m_mask)});
    end

    clear_all();
    wr(2'd1, 32'h0);
    chk("R2 clear all", status, 32'h0);

    // R2 set wins over clear in the same cycle
    evt = 32'h1; wr_en = 1'b1; wr_sel = 2'd0; wr_data = 32'h1;
    cyc();
    evt = '0; wr_en = 1'b0;
    chk("R2 set wins", status, 32'h1);
    wr(2'd0, 32'h0);
    chk("R2 zero write no effect", status, 32'h1);
    wr(2'd0, 32'h1);

    // R1 summary position ignored on evt_i
    pulse(32'h2000_0000, 32'h0);
    chk("R1 summary evt ignored", status, 32'h0);

    // R6 undefined DMA bit ignored
    pulse(32'h0, 32'h0000_0020);
    chk("R6 undefined dma bit", dma_status, 32'h0);

    // R7 summaries follow DMA and ignore host clears
    pulse(32'h0, 32'h0000_0002);
    chk("R7 tx summary", status, 32'h0800_0000);
    wr(2'd0, 32'h0800_0000);
    chk("R7 summary write ignored", status, 32'h0800_0000);
    wr(2'd2, 32'h0000_0002);
    chk("R7 summary drops", status, 32'h0);
    pulse(32'h0, 32'h8000_0000);
    chk("R7 error summary", status, 32'h2000_0000);
    clear_all();

    // R4 coalescing window C=2
    wr(2'd3, 32'h0000_0002);
    wr(2'd1, 32'h0000_0001);
    pulse(32'h1, 32'h0);
    chk("R4 irq held at event", {31'd0, irq}, 32'h0);
    count_irq(n);
    chk("R4 window edges", n, 65);
    repeat (10) cyc();
    chk("R5 irq stays high", {31'd0, irq}, 32'h1);
    wr(2'd0, 32'h1);
    chk("R5 irq drops when drained", {31'd0, irq}, 32'h0);
    pulse(32'h1, 32'h0);
    chk("R5 new window held", {31'd0, irq}, 32'h0);
    count_irq(n);
    chk("R5 new window edges", n, 65);
    wr(2'd0, 32'h1);
    repeat (2) cyc();

    // R4 tick gating
    us_tick = 1'b0;
    pulse(32'h1, 32'h0);
    repeat (199) cyc();
    chk("R4 no progress without tick", {31'd0, irq}, 32'h0);
    us_tick = 1'b1;
    count_irq(n);
    chk("R4 resumed window edges", n, 64);
    wr(2'd0, 32'h1);
    repeat (2) cyc();

    // R8 high-priority bypass
    wr(2'd1, 32'h8000_0000);
    pulse(32'h0, 32'h0001_0000);
    chk("R8 normal rx coalesced", {31'd0, irq}, 32'h0);
    wr(2'd2, 32'h0001_0000);
    repeat (2) cyc();
    pulse(32'h0, 32'h4000_0000);
    chk("R8 hipri immediate", {31'd0, irq}, 32'h1);
    chk("R7 hipri rx summary", status, 32'h8000_0000);
    clear_all();
    wr(2'd1, 32'h0);

    // R9 periodic P=1
    wr(2'd3, 32'h0000_0100);
    n = 0;
    while (!status[28] && n < 400) begin
      cyc();
      n++;
    end
    chk("R9 first period edges", n, 33);
    wr(2'd0, 32'h1000_0000);
    n = 0;
    while (!status[28] && n < 400) begin
      cyc();
      n++;
    end
    chk("R9 steady period edges", n, 31);
    wr(2'd3, 32'h0000_0000);
    wr(2'd0, 32'h1000_0000);
    repeat (100) cyc();
    chk("R9 periodic off", status, 32'h0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule